// File: doc/BRIEF.md
# SPI Mode 0 Target Word Exchanger

This block is the target (slave) end of a full-duplex SPI link running clock polarity 0 and clock phase 0. While the select line is low, an external controller clocks one word into the block on `spi_mosi` and, on the same clock edges, takes a word back from `spi_miso`. The word sent back is taken from `rsp_byte` at the moment select goes low. The word received is shown on `rcv_byte`, and `rcv_valid` marks it.

The block runs entirely on the system clock `clk`. The three serial inputs pass through a synchronizer chain of `SYNC_STAGES` flops, and serial clock and select edges are found by comparing each synchronized value with the one from the cycle before. With the default two-stage chain, an edge at a pin is acted on at the third rising `clk` edge after the pin changes. The serial clock half period must therefore be at least four system clocks.

The received side has no back-pressure. A serial link cannot be stalled, so `rcv_valid` is a pulse that lasts one cycle and the consumer has to take the word in that cycle. It can also read the word later, because `rcv_byte` holds it until the next complete word. The response side has no handshake either: `rsp_byte` only has to be stable when select falls. Bits travel most significant first. When more than `W` bits are clocked within one selection, the receive side starts a new word, and after the response word has been sent `spi_miso` shifts out zeros.

Top module: `spi_m0_target`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), and at the first cycle after it is released, `spi_miso`, `rcv_valid` and `rcv_byte` are all 0.
- R2: The response word is captured from `rsp_byte` when the falling edge of select is detected. A change of `rsp_byte` after that has no effect on the bits sent in the current selection.
- R3: When select falls, the most significant bit of the captured response appears on `spi_miso` before the first rising edge of the serial clock, with a delay of `SYNC_STAGES`+1 system clocks.
- R4: On each falling edge of the serial clock while selected, `spi_miso` moves to the next lower bit of the response. The controller therefore reads the response MSB first on rising edges.
- R5: `spi_mosi` is sampled on each rising edge of the serial clock while selected, MSB first. After `W` such edges, `rcv_byte` equals the word the controller sent.
- R6: `rcv_valid` is high for exactly one system clock for each complete word. It rises at the third `clk` edge after the pin-level `W`-th rising serial clock edge, and `rcv_byte` changes in that same cycle.
- R7: If select rises before `W` bits have arrived, `rcv_valid` does not pulse and `rcv_byte` keeps its previous value. The next selection starts again at bit 0.
- R8: Receive and transmit are independent. The received word is unaffected by the response word, including when both carry complementary or identical patterns.
- R9: While select is high, serial clock activity is ignored: `spi_miso` stays 0, `rcv_valid` stays 0 and `rcv_byte` does not change.
- R10: `rcv_byte` changes only in a cycle where `rcv_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rsp_byte | input | W | Response word, captured when select falls |
| rcv_byte | output | W | Last complete word received |
| rcv_valid | output | 1 | One-cycle pulse: a new word is on `rcv_byte` |
| spi_clk | input | 1 | Serial clock from the controller, idles low |
| spi_sel_n | input | 1 | Select from the controller, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |

## Verification
The hardest conditions to reach from the ports are a selection that ends partway through a word, and serial clock edges that arrive while the block is deselected. Both hide state the ports cannot show directly: the internal bit position, and a response register that could leak onto `spi_miso`. The bench's controller task takes a bit count, so it can end a selection after any number of bits and then toggle the serial clock with select high. A full word sent after that shows that counting restarted at bit 0. The same task can change `rsp_byte` in the middle of a selection, to show that the captured response is kept.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;

  // Edge events seen on the synchronized serial inputs, one system clock wide.
  typedef struct packed {
    logic sel_act;   // select currently low (synchronized)
    logic sel_fall;  // select went low this cycle
    logic sel_rise;  // select went high this cycle
    logic clk_rise;  // serial clock rising edge
    logic clk_fall;  // serial clock falling edge
    logic din;       // synchronized serial data in
  } spi_evt_t;

  // Idle levels of the serial inputs {clk, sel_n, data}.
  localparam logic [2:0] SPI_IDLE = 3'b010;

endpackage

// File: rtl/spi_m0_sync.sv
module spi_m0_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_m0_edges.sv
module spi_m0_edges
  import spi_m0_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     sel_n_s,
  input  logic     mosi_s,
  output spi_evt_t evt
);

  logic sclk_prev_q;
  logic sel_n_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q  <= SPI_IDLE[2];
      sel_n_prev_q <= SPI_IDLE[1];
    end else begin
      sclk_prev_q  <= sclk_s;
      sel_n_prev_q <= sel_n_s;
    end
  end

  always_comb begin
    evt.sel_act  = ~sel_n_s;
    evt.sel_fall = ~sel_n_s &  sel_n_prev_q;
    evt.sel_rise =  sel_n_s & ~sel_n_prev_q;
    evt.clk_rise =  sclk_s  & ~sclk_prev_q;
    evt.clk_fall = ~sclk_s  &  sclk_prev_q;
    evt.din      =  mosi_s;
  end

endmodule

// File: rtl/spi_m0_txpath.sv
module spi_m0_txpath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_act,
  input  logic         sel_fall,
  input  logic         sel_rise,
  input  logic         clk_fall,
  input  logic [W-1:0] rsp_byte,
  output logic         miso
);

  logic [W-1:0] tx_buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf_q <= '0;
    end else if (sel_fall) begin
      tx_buf_q <= rsp_byte;
    end else if (sel_rise) begin
      tx_buf_q <= '0;
    end else if (sel_act && clk_fall) begin
      tx_buf_q <= {tx_buf_q[W-2:0], 1'b0};
    end
  end

  assign miso = tx_buf_q[W-1];

endmodule

// File: rtl/spi_m0_rxpath.sv
module spi_m0_rxpath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_act,
  input  logic         sel_fall,
  input  logic         sel_rise,
  input  logic         clk_rise,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         word_valid
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] bit_cnt_q;
  logic [W-1:0]     shift_q;
  logic [W-1:0]     next_shift;

  assign next_shift = {shift_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (sel_fall || sel_rise) begin
        bit_cnt_q <= '0;
      end else if (sel_act && clk_rise) begin
        shift_q <= next_shift;
        if (bit_cnt_q == LAST) begin
          bit_cnt_q  <= '0;
          word       <= next_shift;
          word_valid <= 1'b1;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_m0_target.sv
module spi_m0_target
  import spi_m0_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rsp_byte,
  output logic [W-1:0] rcv_byte,
  output logic         rcv_valid,
  input  logic         spi_clk,
  input  logic         spi_sel_n,
  input  logic         spi_mosi,
  output logic         spi_miso
);

  logic [2:0] pins_s;
  spi_evt_t   evt;

  spi_m0_sync #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SPI_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({spi_clk, spi_sel_n, spi_mosi}),
    .dout  (pins_s)
  );

  spi_m0_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[2]),
    .sel_n_s (pins_s[1]),
    .mosi_s  (pins_s[0]),
    .evt     (evt)
  );

  spi_m0_txpath #(.W(W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_act  (evt.sel_act),
    .sel_fall (evt.sel_fall),
    .sel_rise (evt.sel_rise),
    .clk_fall (evt.clk_fall),
    .rsp_byte (rsp_byte),
    .miso     (spi_miso)
  );

  spi_m0_rxpath #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_act    (evt.sel_act),
    .sel_fall   (evt.sel_fall),
    .sel_rise   (evt.sel_rise),
    .clk_rise   (evt.clk_rise),
    .din        (evt.din),
    .word       (rcv_byte),
    .word_valid (rcv_valid)
  );

endmodule

// File: rtl/spi_m0_chk.sv
module spi_m0_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rsp_msb,
  input logic [W-1:0] rcv_byte,
  input logic         rcv_valid,
  input logic         spi_miso,
  input logic         sel_act,
  input logic         sel_fall
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_valid |=> !rcv_valid);  // R6

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rcv_byte) |-> rcv_valid);  // R10

  AST_VALID_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_valid |-> $past(sel_act));  // R7

  AST_MSB_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> (spi_miso == $past(rsp_msb)));  // R3

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_act && !$past(sel_act)) |-> !spi_miso);  // R9

endmodule

bind spi_m0_target spi_m0_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_msb   (rsp_byte[W-1]),
  .rcv_byte  (rcv_byte),
  .rcv_valid (rcv_valid),
  .spi_miso  (spi_miso),
  .sel_act   (evt.sel_act),
  .sel_fall  (evt.sel_fall)
);

// File: tb/sim_spi_m0_target.sv
`timescale 1ns/1ps
module sim_spi_m0_target;

  localparam int W = 8;
  localparam int H = 5;  // serial half period in system clocks

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] rsp_byte = '0;
  logic [W-1:0] rcv_byte;
  logic         rcv_valid;
  logic         spi_clk = 1'b0;
  logic         spi_sel_n = 1'b1;
  logic         spi_mosi = 1'b0;
  logic         spi_miso;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_m0_target #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .rsp_byte(rsp_byte), .rcv_byte(rcv_byte),
    .rcv_valid(rcv_valid), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // Pin history: a = seen at last edge, b = the one before, c = before that.
  int ha_c, hb_c, hc_c, ha_s, hb_s, hc_s, ha_d, hb_d;
  int m_tx, m_cnt, m_sh, m_rx;
  bit m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      ha_c = 0; hb_c = 0; hc_c = 0;
      ha_s = 1; hb_s = 1; hc_s = 1;
      ha_d = 0; hb_d = 0;
      m_tx = 0; m_cnt = 0; m_sh = 0; m_rx = 0; m_valid = 0;
    end else begin
      bit act, rise, fall, sfall, srise;
      act   = (hb_s == 0);
      rise  = (hb_c == 1) && (hc_c == 0);
      fall  = (hb_c == 0) && (hc_c == 1);
      sfall = (hb_s == 0) && (hc_s == 1);
      srise = (hb_s == 1) && (hc_s == 0);
      m_valid = 0;
      if (sfall)             m_tx = int'(rsp_byte);
      else if (srise)        m_tx = 0;
      else if (act && fall)  m_tx = (m_tx << 1) & 255;
      if (sfall || srise) m_cnt = 0;
      else if (act && rise) begin
        m_sh = ((m_sh << 1) | hb_d) & 255;
        if (m_cnt == W - 1) begin
          m_rx = m_sh; m_valid = 1; m_cnt = 0;
        end else m_cnt++;
      end
      hc_c = hb_c; hb_c = ha_c; ha_c = int'(spi_clk);
      hc_s = hb_s; hb_s = ha_s; ha_s = int'(spi_sel_n);
      hb_d = ha_d; ha_d = int'(spi_mosi);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R4 miso vs model", int'(spi_miso), (m_tx >> (W - 1)) & 1);
      chk("R6 rcv_valid vs model", int'(rcv_valid), int'(m_valid));
      chk("R5 rcv_byte vs model", int'(rcv_byte), m_rx);
      if (rcv_valid) vcount++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Controller: nbits bits of mo, optional response change mid-frame.
  task automatic xfer(input logic [W-1:0] mo, input logic [W-1:0] rsp,
                      input int nbits, input bit swap_rsp,
                      output logic [W-1:0] got);
    got = '0;
    rsp_byte = rsp;
    wait_cyc(2);
    spi_sel_n = 1'b0;
    spi_mosi  = mo[W-1];
    wait_cyc(H);
    if (swap_rsp) rsp_byte = ~rsp;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = mo[W-1-i];
      wait_cyc(H);
      spi_clk = 1'b1;
      got[W-1-i] = spi_miso;
      wait_cyc(H);
      spi_clk = 1'b0;
    end
    wait_cyc(H);
    spi_sel_n = 1'b1;
    spi_mosi  = 1'b0;
    wait_cyc(8);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] got;
    int v0;
    wait_cyc(3);
    chk("R1 miso in reset", int'(spi_miso), 0);
    chk("R1 valid in reset", int'(rcv_valid), 0);
    chk("R1 byte in reset", int'(rcv_byte), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 byte after reset", int'(rcv_byte), 0);

    // R3: MSB present before first rising edge
    rsp_byte = 8'h81;
    wait_cyc(2);
    spi_sel_n = 1'b0;
    wait_cyc(2);
    chk("R3 miso not yet", int'(spi_miso), 0);
    wait_cyc(1);
    chk("R3 msb on select", int'(spi_miso), 1);
    spi_sel_n = 1'b1;
    wait_cyc(8);
    chk("R9 miso after deselect", int'(spi_miso), 0);

    // R4 R5 R6: full words
    v0 = vcount;
    xfer(8'hA5, 8'h5A, W, 0, got);
    chk("R4 response bits", int'(got), 8'h5A);
    chk("R5 received word", int'(rcv_byte), 8'hA5);
    chk("R6 one pulse", vcount - v0, 1);

    // R8: complementary and identical patterns
    xfer(8'h0F, 8'hF0, W, 0, got);
    chk("R8 rx complement", int'(rcv_byte), 8'h0F);
    chk("R8 tx complement", int'(got), 8'hF0);
    xfer(8'h3C, 8'h3C, W, 0, got);
    chk("R8 rx same", int'(rcv_byte), 8'h3C);
    chk("R8 tx same", int'(got), 8'h3C);

    // R2: response change mid-frame ignored
    xfer(8'h96, 8'hC3, W, 1, got);
    chk("R2 captured response", int'(got), 8'hC3);
    chk("R5 word with swap", int'(rcv_byte), 8'h96);

    // R7: aborted word
    v0 = vcount;
    xfer(8'hFF, 8'h11, 5, 0, got);
    chk("R7 no pulse on abort", vcount - v0, 0);
    chk("R7 byte kept on abort", int'(rcv_byte), 8'h96);

    // R9: serial clock toggles while deselected
    v0 = vcount;
    for (int k = 0; k < 12; k++) begin
      spi_mosi = k[0];
      wait_cyc(H);
      spi_clk = ~spi_clk;
      chk("R9 miso idle", int'(spi_miso), 0);
    end
    spi_clk = 1'b0;
    wait_cyc(8);
    chk("R9 no pulse idle", vcount - v0, 0);
    chk("R10 byte held idle", int'(rcv_byte), 8'h96);

    // R7: restart at bit 0 after abort
    v0 = vcount;
    xfer(8'h01, 8'h80, W, 0, got);
    chk("R7 restart word", int'(rcv_byte), 8'h01);
    chk("R7 restart response", int'(got), 8'h80);
    chk("R6 one pulse again", vcount - v0, 1);
    wait_cyc(20);
    chk("R10 byte stable", int'(rcv_byte), 8'h01);

    finish_run();
  end

endmodule